// File: doc/BRIEF.md
# Three-Mode Core Interrupt Timer

This block is the interrupt timer of one processor core. Software programs it through a small register port. It then raises a one-cycle interrupt request that carries a programmed vector number. The timer runs in one of three ways. In one-shot mode it counts down once. In periodic mode it counts down and reloads. In deadline mode it compares a 64-bit absolute deadline against a free-running timestamp counter, which comes in on an input port.

A control word holds the vector, a mask bit and a mode field. The mode field decides how every other register behaves: what a read returns, whether a write is accepted, and whether it arms the timer. Changing the mode always disarms whatever was running. Delivery and arbitration of the request happen elsewhere.

Register addresses on `reg_addr` and `rd_addr`:
- 0: control word
- 1: start count
- 2: live count (read-only)
- 3: prescale code
- 4: deadline

Addresses 5 to 7 read as 0.

Top module: `core_irq_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (masked, vector 0, one-shot). Start count, live count, prescale code and deadline all read 0, and `irq_valid` is low.
- R2: A control-word write keeps only bits 7:0 (vector), bit 16 (mask) and bits 18:17 (mode: 00 one-shot, 01 periodic, 10 deadline, 11 reserved); all other bits read back 0. While `sw_enable` is low, the stored mask bit is forced to 1.
- R3: In one-shot mode, writing start count N with prescale code k (bits 2:0, ratio 2^k) gives a single interrupt pulse. The pulse is visible in the cycle after clock edge W+N·2^k, where W is the write edge. The timer is disarmed afterwards.
- R4: In periodic mode the pulses repeat every max(N·2^k, MIN_PERIOD) cycles. A new start-count write restarts the count from its own write edge.
- R5: In one-shot or periodic mode, a start count of 0 leaves the timer disarmed and the live count reads 0.
- R6: The live count reads the remaining timer-clock cycles shifted right by the current prescale code. In deadline mode it reads 0.
- R7: In deadline mode, start-count writes are ignored: the stored value is unchanged and nothing is armed.
- R8: Outside deadline mode, the deadline register reads 0 and writes to it are ignored.
- R9: In deadline mode, writing a deadline D arms the timer. The pulse follows the first clock edge at which `tsc` ≥ D, which is the edge right after the write when D is already due. The deadline then reads 0.
- R10: Writing a deadline of 0 leaves the timer disarmed.
- R11: A control-word write that changes the mode cancels any armed count or deadline. A write that keeps the mode does not disturb a running count.
- R12: While the mask bit is set, an expiry produces no pulse but still takes its effect: one-shot disarms, periodic reloads.
- R13: In reserved mode nothing arms. A start-count write is stored but not started, and the live count and deadline read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_enable | input | 1 | Controller software enable; low forces the mask bit on control writes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | TSC_W | Write data (32-bit registers use the low bits) |
| rd_addr | input | 3 | Read address |
| rd_data | output | TSC_W | Combinational read data |
| tsc | input | TSC_W | Free-running timestamp counter |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | VEC_W | Vector carried with the pulse |

## Verification
A register write lands on one clock edge. Its effect on reads is visible right after that edge, and reads are purely combinational from the stored state. A countdown pulse appears exactly N·2^k edges after the write edge (or MIN_PERIOD edges when periodic clamping applies). A deadline pulse appears after the edge at which `tsc` first reaches the deadline. The bench records the edge number of every write and every pulse, and compares them against these offsets. A behavioural model is stepped on the same edges and compared 3 ns after each edge, before the inputs move on the falling edge.

// File: rtl/cit_pkg.sv
// Shared types and register layout for the core interrupt timer.
// Assumes a single write port and a single combinational read port.
package cit_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RESERVED = 2'b11
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_START = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_LIVE  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_PRESC = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_DLINE = 3'd4;

    localparam int MASK_BIT = 16;
    localparam int MODE_LSB = 17;

endpackage

// File: rtl/cit_regs.sv
// Control word, start count and prescale code storage.
// Flags a mode change and a countdown start for the counting logic.
// Assumes at most one write per cycle; the mode field decides acceptance.
module cit_regs
    import cit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 3,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_enable,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             wr_mask,
    input  logic [1:0]       wr_mode,
    input  logic [CNT_W-1:0] wr_count,
    input  logic [DIV_W-1:0] wr_div,
    output logic [VEC_W-1:0] vector,
    output logic             masked,
    output tmr_mode_e        mode,
    output logic [CNT_W-1:0] start_count,
    output logic [DIV_W-1:0] div_code,
    output logic             mode_change,
    output logic             count_load
);

    logic ctrl_wr;
    logic start_wr;
    logic presc_wr;

    // decode the single write port
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        start_wr = wr_en && (wr_addr == ADDR_START);
        presc_wr = wr_en && (wr_addr == ADDR_PRESC);
    end

    // raise the cancel and start strobes
    always_comb begin
        mode_change = ctrl_wr && (tmr_mode_e'(wr_mode) != mode);
        count_load  = start_wr && ((mode == MODE_ONESHOT) || (mode == MODE_PERIODIC));
    end

    // control word: vector, forced mask, mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vector <= '0;
            masked <= 1'b1;
            mode   <= MODE_ONESHOT;
        end else if (ctrl_wr) begin
            vector <= wr_vec;
            masked <= wr_mask | ~sw_enable;
            mode   <= tmr_mode_e'(wr_mode);
        end
    end

    // start count, refused in deadline mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_count <= '0;
        end else if (start_wr && (mode != MODE_DEADLINE)) begin
            start_count <= wr_count;
        end
    end

    // prescale code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_code <= '0;
        end else if (presc_wr) begin
            div_code <= wr_div;
        end
    end

endmodule

// File: rtl/cit_count.sv
// Countdown engine for one-shot and periodic modes.
// Holds the remaining span in timer-clock cycles; the prescale is applied
// once at load by shifting, and periodic spans are clamped to MIN_PERIOD.
// Assumes cancel and load never coincide (one write port upstream).
module cit_count #(
    parameter  int CNT_W      = 32,
    parameter  int DIV_W      = 3,
    parameter  int MIN_PERIOD = 16,
    localparam int REM_W      = CNT_W + (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periodic,
    input  logic             cancel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    input  logic [CNT_W-1:0] start_count,
    input  logic [DIV_W-1:0] div_code,
    output logic [REM_W-1:0] remaining,
    output logic             fire
);

    // span in cycles for a count and prescale, clamped if periodic
    function automatic logic [REM_W-1:0] span_of(input logic [CNT_W-1:0] c,
                                                 input logic [DIV_W-1:0] k,
                                                 input logic per);
        logic [REM_W-1:0] s;
        s = REM_W'(c) << k;
        if (per && (s != '0) && (s < REM_W'(MIN_PERIOD))) begin
            s = REM_W'(MIN_PERIOD);
        end
        return s;
    endfunction

    logic last_cycle;

    // expiry strobe, suppressed by a same-cycle restart or cancel
    always_comb begin
        last_cycle = (remaining == REM_W'(1));
        fire       = last_cycle && !cancel && !load;
    end

    // remaining-cycle register: cancel, load, reload or step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (cancel) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= span_of(load_count, div_code, periodic);
        end else if (last_cycle) begin
            remaining <= periodic ? span_of(start_count, div_code, 1'b1) : '0;
        end else if (remaining != '0) begin
            remaining <= remaining - REM_W'(1);
        end
    end

endmodule

// File: rtl/cit_deadline.sv
// Absolute deadline register and comparator against the timestamp input.
// A nonzero value in deadline mode is armed; expiry clears it to 0.
// Assumes the timestamp only moves forward.
module cit_deadline #(
    parameter int TSC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dl_mode,
    input  logic             cancel,
    input  logic             wr_en,
    input  logic [TSC_W-1:0] wr_value,
    input  logic [TSC_W-1:0] tsc,
    output logic [TSC_W-1:0] deadline,
    output logic             fire
);

    logic accept;

    // expiry when armed and due, unless rewritten or cancelled now
    always_comb begin
        accept = wr_en && dl_mode;
        fire   = dl_mode && (deadline != '0) && (tsc >= deadline) && !accept && !cancel;
    end

    // deadline register: cancel, rewrite, clear on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline <= '0;
        end else if (cancel) begin
            deadline <= '0;
        end else if (accept) begin
            deadline <= wr_value;
        end else if (fire) begin
            deadline <= '0;
        end
    end

endmodule

// File: rtl/core_irq_timer.sv
// Per-core interrupt timer with one-shot, periodic and deadline modes.
// Ties the register store, the countdown engine and the deadline comparator
// together, muxes reads and registers the interrupt pulse.
// Assumes VEC_W <= 16 and TSC_W >= max(CNT_W, 19).
module core_irq_timer
    import cit_pkg::*;
#(
    parameter  int CNT_W      = 32,
    parameter  int DIV_W      = 3,
    parameter  int VEC_W      = 8,
    parameter  int TSC_W      = 64,
    parameter  int MIN_PERIOD = 16,
    localparam int REM_W      = CNT_W + (1 << DIV_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TSC_W-1:0]  reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TSC_W-1:0]  rd_data,
    input  logic [TSC_W-1:0]  tsc,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [VEC_W-1:0] lvt_vector;
    logic             lvt_masked;
    tmr_mode_e        lvt_mode;
    logic [CNT_W-1:0] start_count;
    logic [DIV_W-1:0] div_code;
    logic             mode_change;
    logic             count_load;
    logic [REM_W-1:0] cnt_remaining;
    logic             cnt_fire;
    logic [TSC_W-1:0] dl_value;
    logic             dl_fire;
    logic             dl_wr;
    logic [CNT_W-1:0] live_count;
    logic [TSC_W-1:0] ctrl_word;

    cit_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .VEC_W(VEC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_enable  (sw_enable),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_vec     (reg_wdata[VEC_W-1:0]),
        .wr_mask    (reg_wdata[MASK_BIT]),
        .wr_mode    (reg_wdata[MODE_LSB+1:MODE_LSB]),
        .wr_count   (reg_wdata[CNT_W-1:0]),
        .wr_div     (reg_wdata[DIV_W-1:0]),
        .vector     (lvt_vector),
        .masked     (lvt_masked),
        .mode       (lvt_mode),
        .start_count(start_count),
        .div_code   (div_code),
        .mode_change(mode_change),
        .count_load (count_load)
    );

    cit_count #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_PERIOD(MIN_PERIOD)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .periodic   (lvt_mode == MODE_PERIODIC),
        .cancel     (mode_change),
        .load       (count_load),
        .load_count (reg_wdata[CNT_W-1:0]),
        .start_count(start_count),
        .div_code   (div_code),
        .remaining  (cnt_remaining),
        .fire       (cnt_fire)
    );

    // deadline write strobe
    always_comb dl_wr = reg_wr && (reg_addr == ADDR_DLINE);

    cit_deadline #(.TSC_W(TSC_W)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .dl_mode (lvt_mode == MODE_DEADLINE),
        .cancel  (mode_change),
        .wr_en   (dl_wr),
        .wr_value(reg_wdata),
        .tsc     (tsc),
        .deadline(dl_value),
        .fire    (dl_fire)
    );

    // assemble the control word and the prescaled live count
    always_comb begin
        ctrl_word                          = '0;
        ctrl_word[VEC_W-1:0]               = lvt_vector;
        ctrl_word[MASK_BIT]                = lvt_masked;
        ctrl_word[MODE_LSB+1:MODE_LSB]     = lvt_mode;
        live_count = CNT_W'(cnt_remaining >> div_code);
    end

    // mode-dependent read mux
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL:  rd_data = ctrl_word;
            ADDR_START: rd_data = TSC_W'(start_count);
            ADDR_LIVE:  if (lvt_mode == MODE_ONESHOT || lvt_mode == MODE_PERIODIC)
                            rd_data = TSC_W'(live_count);
            ADDR_PRESC: rd_data = TSC_W'(div_code);
            ADDR_DLINE: if (lvt_mode == MODE_DEADLINE) rd_data = dl_value;
            default:    rd_data = '0;
        endcase
    end

    // one-cycle interrupt pulse unless masked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= (cnt_fire || dl_fire) && !lvt_masked;
            if (cnt_fire || dl_fire) begin
                irq_vector <= lvt_vector;
            end
        end
    end

endmodule

// File: rtl/cit_checker.sv
// Property checker for core_irq_timer, attached by bind below.
// Observes ports and the state held by the separate sub-blocks.
module cit_checker
    import cit_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int REM_W = 39,
    parameter int TSC_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_enable,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [TSC_W-1:0]  reg_wdata,
    input logic              irq_valid,
    input logic              lvt_mask,
    input logic [1:0]        lvt_mode,
    input logic [CNT_W-1:0]  start_count,
    input logic [REM_W-1:0]  remaining,
    input logic [TSC_W-1:0]  deadline
);

    // R2
    mask_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CTRL && !sw_enable) |=> lvt_mask);

    // R12
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(lvt_mask));

    // R7
    start_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_START && lvt_mode == 2'b10) |=> $stable(start_count));

    // R8
    deadline_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvt_mode != 2'b10) |-> (deadline == '0));

    // R9
    deadline_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && lvt_mode == 2'b10) |-> (deadline == '0));

    // R13
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvt_mode == 2'b11) |-> (remaining == '0 && deadline == '0));

    // R5
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_START && reg_wdata[CNT_W-1:0] == '0 &&
         lvt_mode[1] == 1'b0) |=> (remaining == '0));

endmodule

bind core_irq_timer cit_checker #(.CNT_W(CNT_W), .REM_W(REM_W), .TSC_W(TSC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_enable  (sw_enable),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .irq_valid  (irq_valid),
    .lvt_mask   (lvt_masked),
    .lvt_mode   (lvt_mode),
    .start_count(start_count),
    .remaining  (cnt_remaining),
    .deadline   (dl_value)
);

// File: tb/core_irq_timer_bench.sv
// Bench for core_irq_timer: a behavioural model stepped on every edge and
// compared 3 ns later, plus directed checks on pulse timing per requirement.
module core_irq_timer_bench;
    import cit_pkg::*;

    localparam int MINP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [63:0] tsc = 64'd1000;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          irq_cyc[$];
    logic [63:0] irq_tsc[$];
    logic [7:0]  irq_vec[$];

    // 100 MHz clock
    always #5 clk = ~clk;

    core_irq_timer #(.MIN_PERIOD(MINP)) u_core_irq_timer (
        .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .tsc(tsc), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) tsc <= tsc + 64'd1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]      m_vec = '0;
    bit              m_mask = 1'b1;
    logic [1:0]      m_mode = 2'b00;
    logic [31:0]     m_start = '0;
    logic [2:0]      m_div = '0;
    longint unsigned m_rem = 0;
    logic [63:0]     m_dl = '0;
    bit              m_irq = 1'b0;
    logic [7:0]      m_ivec = '0;

    function automatic longint unsigned span(input logic [31:0] c, input logic [2:0] k,
                                             input bit per);
        longint unsigned s;
        s = longint'(c) << k;
        if (per && s != 0 && s < MINP) s = MINP;
        return s;
    endfunction

    function automatic logic [63:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return {45'd0, m_mode, m_mask, 8'd0, m_vec};
            3'd1: return {32'd0, m_start};
            3'd2: return (m_mode[1] == 1'b0) ? ((m_rem >> m_div) & 64'hFFFF_FFFF) : 64'd0;
            3'd3: return {61'd0, m_div};
            3'd4: return (m_mode == 2'b10) ? m_dl : 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_for(input logic [1:0] md);
        case (md)
            2'b00: return "R3 model";
            2'b01: return "R4 model";
            2'b10: return "R9 model";
            default: return "R13 model";
        endcase
    endfunction

    always @(posedge clk) begin
        bit fc, fd;
        longint unsigned n_rem;
        logic [63:0] n_dl;
        logic [7:0] n_vec;
        bit n_mask;
        logic [1:0] n_mode;
        logic [31:0] n_start;
        logic [2:0] n_div;
        if (!rst_n) begin
            m_vec = '0; m_mask = 1'b1; m_mode = 2'b00; m_start = '0; m_div = '0;
            m_rem = 0; m_dl = '0; m_irq = 1'b0; m_ivec = '0;
        end else begin
            fc = (m_rem == 1);
            fd = (m_mode == 2'b10) && (m_dl != 0) && (tsc >= m_dl);
            n_rem = m_rem; n_dl = m_dl; n_vec = m_vec; n_mask = m_mask;
            n_mode = m_mode; n_start = m_start; n_div = m_div;
            if (m_rem == 1) n_rem = (m_mode == 2'b01) ? span(m_start, m_div, 1'b1) : 0;
            else if (m_rem != 0) n_rem = m_rem - 1;
            if (fd) n_dl = '0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin
                        n_mode = reg_wdata[18:17];
                        n_vec = reg_wdata[7:0];
                        n_mask = reg_wdata[16] | !sw_enable;
                        if (n_mode != m_mode) begin
                            n_rem = 0; n_dl = '0; fc = 1'b0; fd = 1'b0;
                        end
                    end
                    3'd1: if (m_mode != 2'b10) begin
                        n_start = reg_wdata[31:0];
                        if (m_mode[1] == 1'b0) begin
                            n_rem = span(reg_wdata[31:0], m_div, m_mode == 2'b01);
                            fc = 1'b0;
                        end
                    end
                    3'd3: n_div = reg_wdata[2:0];
                    3'd4: if (m_mode == 2'b10) begin
                        n_dl = reg_wdata; fd = 1'b0;
                    end
                    default: ;
                endcase
            end
            m_irq = (fc || fd) && !m_mask;
            if (fc || fd) m_ivec = m_vec;
            m_vec = n_vec; m_mask = n_mask; m_mode = n_mode; m_start = n_start;
            m_div = n_div; m_rem = n_rem; m_dl = n_dl;
        end
    end

    // compare the design with the model away from the edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(irq_valid == m_irq, tag_for(m_mode), {63'd0, irq_valid}, {63'd0, m_irq});
            if (irq_valid && m_irq)
                check(irq_vector == m_ivec, tag_for(m_mode), {56'd0, irq_vector}, {56'd0, m_ivec});
            check(rd_data == model_read(rd_addr), tag_for(m_mode), rd_data, model_read(rd_addr));
            if (irq_valid) begin
                irq_cyc.push_back(cyc);
                irq_tsc.push_back(tsc);
                irq_vec.push_back(irq_vector);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [63:0] d, output int e);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 e = cyc;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    function automatic int count_irq(input int lo, input int hi);
        int n = 0;
        foreach (irq_cyc[i]) if (irq_cyc[i] > lo && irq_cyc[i] <= hi) n++;
        return n;
    endfunction

    function automatic int find_irq(input int c);
        foreach (irq_cyc[i]) if (irq_cyc[i] == c) return i;
        return -1;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 20000", cyc);
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [63:0] v;
        logic [63:0] dl_target;
        int e, w, w2, m, k;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check(v == 64'h1_0000, "R1 control", v, 64'h1_0000);
        rd(3'd1, v); check(v == 0, "R1 start", v, 0);
        rd(3'd2, v); check(v == 0, "R1 live", v, 0);
        rd(3'd3, v); check(v == 0, "R1 prescale", v, 0);
        rd(3'd4, v); check(v == 0, "R1 deadline", v, 0);
        check(irq_valid == 1'b0, "R1 irq", {63'd0, irq_valid}, 0);

        // R2 field filtering and forced mask
        wr(3'd0, 64'hFFF0_12AB, e);
        rd(3'd0, v); check(v == 64'hAB, "R2 filter", v, 64'hAB);
        sw_enable = 1'b0;
        wr(3'd0, 64'h42, e);
        rd(3'd0, v); check(v == 64'h1_0042, "R2 forced mask", v, 64'h1_0042);
        sw_enable = 1'b1;

        // R3 one-shot, R6 live count
        wr(3'd0, 64'h20, e);
        wr(3'd3, 64'd1, e);
        wr(3'd1, 64'd5, w);
        repeat (4) @(posedge clk);
        rd(3'd2, v); check(v == 3, "R6 live count", v, 3);
        repeat (40) @(negedge clk);
        check(find_irq(w + 10) >= 0, "R3 one-shot timing", 0, w + 10);
        check(count_irq(w, w + 40) == 1, "R3 single pulse", count_irq(w, w + 40), 1);
        k = find_irq(w + 10);
        if (k >= 0) check(irq_vec[k] == 8'h20, "R3 vector", irq_vec[k], 8'h20);
        rd(3'd2, v); check(v == 0, "R3 disarmed", v, 0);

        // R4 periodic with clamp, then restart
        wr(3'd0, 64'h2_0021, e);
        wr(3'd3, 64'd0, e);
        wr(3'd1, 64'd3, w);
        repeat (35) @(negedge clk);
        check(find_irq(w + MINP) >= 0 && find_irq(w + 2 * MINP) >= 0, "R4 clamped period", 0, w + MINP);
        wr(3'd1, 64'd20, w2);
        repeat (42) @(negedge clk);
        check(find_irq(w2 + 20) >= 0 && find_irq(w2 + 40) >= 0, "R4 period 20", 0, w2 + 20);
        check(count_irq(w2, w2 + 40) == 2, "R4 restart count", count_irq(w2, w2 + 40), 2);

        // R5 zero start count
        wr(3'd1, 64'd0, w);
        repeat (40) @(negedge clk);
        check(count_irq(w, w + 40) == 0, "R5 no pulse", count_irq(w, w + 40), 0);
        rd(3'd2, v); check(v == 0, "R5 live zero", v, 0);

        // R12 masked periodic keeps running, R11 same-mode write keeps count
        wr(3'd1, 64'd20, w);
        repeat (3) @(negedge clk);
        wr(3'd0, 64'h3_0021, e);
        repeat (17) @(negedge clk);
        wr(3'd0, 64'h2_0021, e);
        repeat (20) @(negedge clk);
        check(count_irq(w, w + 39) == 0, "R12 masked silent", count_irq(w, w + 39), 0);
        check(find_irq(w + 40) >= 0, "R11 same-mode keeps count", 0, w + 40);

        // R11 mode change cancels periodic
        wr(3'd0, 64'h21, m);
        repeat (60) @(negedge clk);
        check(count_irq(m, m + 60) == 0, "R11 mode change cancels", count_irq(m, m + 60), 0);

        // R7 start ignored in deadline mode, R6 live zero
        wr(3'd0, 64'h4_0030, e);
        wr(3'd1, 64'd99, e);
        rd(3'd1, v); check(v == 20, "R7 start unchanged", v, 20);
        rd(3'd2, v); check(v == 0, "R6 live in deadline", v, 0);

        // R9 future deadline
        dl_target = tsc + 64'd20;
        wr(3'd4, dl_target, e);
        rd(3'd4, v); check(v == dl_target, "R9 deadline readback", v, dl_target);
        repeat (30) @(negedge clk);
        check(count_irq(e, e + 30) == 1, "R9 one pulse", count_irq(e, e + 30), 1);
        k = find_irq(e + 1);
        foreach (irq_cyc[i]) if (irq_cyc[i] > e && irq_cyc[i] <= e + 30) k = i;
        if (k >= 0) check(irq_tsc[k] == dl_target, "R9 fires at deadline", irq_tsc[k], dl_target);
        rd(3'd4, v); check(v == 0, "R9 cleared", v, 0);

        // R9 past deadline fires next edge
        wr(3'd4, 64'd5, e);
        repeat (3) @(negedge clk);
        check(find_irq(e + 1) >= 0, "R9 past deadline", 0, e + 1);

        // R10 zero deadline
        wr(3'd4, 64'd0, e);
        repeat (30) @(negedge clk);
        check(count_irq(e, e + 30) == 0, "R10 zero deadline", count_irq(e, e + 30), 0);

        // R11 mode change cancels armed deadline
        wr(3'd4, tsc + 64'd40, e);
        wr(3'd0, 64'h2_0030, m);
        rd(3'd4, v); check(v == 0, "R11 deadline hidden", v, 0);
        wr(3'd0, 64'h4_0030, m);
        rd(3'd4, v); check(v == 0, "R11 deadline cancelled", v, 0);
        repeat (60) @(negedge clk);
        check(count_irq(e, e + 70) == 0, "R11 no deadline pulse", count_irq(e, e + 70), 0);

        // R8 deadline ignored in one-shot mode
        wr(3'd0, 64'h30, e);
        wr(3'd4, 64'd7, e);
        rd(3'd4, v); check(v == 0, "R8 deadline reads zero", v, 0);
        repeat (20) @(negedge clk);
        check(count_irq(e, e + 20) == 0, "R8 no pulse", count_irq(e, e + 20), 0);

        // R13 reserved mode
        wr(3'd0, 64'h6_0030, e);
        wr(3'd1, 64'd5, w);
        rd(3'd1, v); check(v == 5, "R13 start stored", v, 5);
        rd(3'd2, v); check(v == 0, "R13 live zero", v, 0);
        wr(3'd4, 64'd3, e);
        rd(3'd4, v); check(v == 0, "R13 deadline zero", v, 0);
        repeat (30) @(negedge clk);
        check(count_irq(w, w + 35) == 0, "R13 no pulse", count_irq(w, w + 35), 0);

        finish_run();
    end

endmodule